// File: doc/BRIEF.md
# Link reinitialization sequencer

This block runs the reinitialization of one serial data-converter link. A sequence can start in two ways. Software writes a request bit in a small control register. An error input can also start one, provided its enable bit is set in the transmit-direction or receive-direction error mask. While a sequence runs, the block holds a synchronous clear on the transport-layer and link-layer logic for a programmable number of link-clock cycles. It shows progress through a busy status bit. It then spends one release cycle before it returns to idle.

The register bits, the masks, the hold length and the SYSREF single-capture arm flag sit outside the clear. A reinitialization never changes them. The arm flag is set only by software and cleared only when the capture logic reports a seen edge. Completion clears the software request bit only when software started the sequence. An error-started sequence clears only the busy indication.

The FSM has three states. SQ_IDLE waits for a trigger. SQ_CLEAR drives the clear and counts down the hold length. SQ_RELEASE is a single cycle with the clear dropped and busy still high. The transitions are: IDLE→CLEAR on an accepted trigger; CLEAR→CLEAR while the count is not exhausted; CLEAR→RELEASE when the count reaches zero; RELEASE→IDLE always.

Top module: `lnk_reinit_ctrl`

Register map (2-bit address, 8-bit data; a read strobe returns data on the next cycle):
- 0, control: bit 0 request (write 1 to start, read 1 while a software sequence runs), bit 1 SYSREF arm (write 1 to set), bit 2 busy (read only).
- 1, hold length in cycles (reset value 8; values below 4 act as 4).
- 2, transmit error enable mask. 3, receive error enable mask.

## Requirements
- R1: A write to address 0 with bit 0 set while idle starts a sequence. At the next clock edge busy rises, the clear rises and the request bit reads 1.
- R2: When a software-started sequence completes, the request bit and busy both return to 0.
- R3: An error bit starts a sequence only if its enable bit (address 2 for transmit, address 3 for receive) is set. The trigger is a rising edge of the OR of all masked error bits.
- R4: During and after an error-started sequence the request bit reads 0, and busy returns to 0 at completion.
- R5: The clear stays high for max(hold, 4) consecutive cycles.
- R6: After the clear falls, busy stays high for exactly one more cycle and then falls.
- R7: While busy (including the release cycle), software requests and error edges are dropped. No further sequence follows and the request bit is not set.
- R8: A masked error held high does not start a second sequence. Setting a mask bit for an error that is already high gives a rising edge and starts one.
- R9: If a software request and an error edge arrive in the same cycle, the sequence counts as software-started: the request bit reads 1 during it and 0 after.
- R10: The masks, the hold length and the SYSREF arm flag keep their values through a sequence. The arm is set by writing bit 1 at address 0 and cleared by the seen-edge input.
- R11: After reset the clear, busy and arm are 0, the control register reads 0 and the hold length reads 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_re | input | 1 | Register read strobe |
| csr_addr | input | 2 | Register address |
| csr_wdata | input | 8 | Write data |
| csr_rdata | output | 8 | Read data, valid the cycle after csr_re |
| tx_err_in | input | 8 | Transmit-direction error flags |
| rx_err_in | input | 8 | Receive-direction error flags |
| sysref_seen | input | 1 | Capture logic saw a SYSREF edge |
| tl_ll_sclr | output | 1 | Synchronous clear to transport and link layers |
| reinit_busy | output | 1 | Reinitialization in progress |
| sysref_arm | output | 1 | SYSREF single-capture armed |

## Verification
A software request and a masked error edge can fall in the same cycle. Which one wins decides whether the request bit is cleared at the end. The bench drives the control write and an error bit rising on the same falling clock edge. It then reads the control register during the sequence, expecting 5, and after it, expecting 0. A behavioural reference model of the register file and the sequencer runs beside the design. Its clear, busy, arm and read data are compared on every cycle, so overlaps of triggers with the release cycle are judged as well.

// File: rtl/lri_pkg.sv
package lri_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_HOLD = 2'd1;
    localparam logic [ADDR_W-1:0] A_TXM  = 2'd2;
    localparam logic [ADDR_W-1:0] A_RXM  = 2'd3;

    localparam int B_REQ  = 0;
    localparam int B_ARM  = 1;
    localparam int B_BUSY = 2;

    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_CLEAR   = 2'd1,
        SQ_RELEASE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/lri_err_qual.sv
module lri_err_qual #(
    parameter int NT = 8,
    parameter int NR = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] tx_err,
    input  logic [NR-1:0] rx_err,
    input  logic [NT-1:0] tx_mask,
    input  logic [NR-1:0] rx_mask,
    output logic          err_rise
);
    logic [NT-1:0] tx_q;
    logic [NR-1:0] rx_q;
    logic          any_tx, any_rx, any_err, prev_q;

    // per-bit qualification of each error flag by its enable
    for (genvar i = 0; i < NT; i++) begin : g_tx
        assign tx_q[i] = tx_err[i] & tx_mask[i];
    end
    for (genvar j = 0; j < NR; j++) begin : g_rx
        assign rx_q[j] = rx_err[j] & rx_mask[j];
    end

    assign any_tx  = |tx_q;
    assign any_rx  = |rx_q;
    assign any_err = any_tx | any_rx;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= any_err;
    end

    assign err_rise = any_err & ~prev_q;

    // R8: an edge cannot repeat on back-to-back cycles
    a_r8_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        err_rise |=> !err_rise);
endmodule

// File: rtl/lri_seq.sv
module lri_seq
    import lri_pkg::*;
#(
    parameter int HOLD_W   = 8,
    parameter int MIN_HOLD = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_req,
    input  logic              err_rise,
    input  logic [HOLD_W-1:0] hold_cfg,
    output logic              sclr,
    output logic              busy,
    output logic              idle,
    output logic              done,
    output logic              done_sw
);
    localparam logic [HOLD_W-1:0] MIN_H = HOLD_W'(MIN_HOLD);
    localparam int LEN_W = HOLD_W + 1;

    seq_state_t        state_q, state_d;
    logic [HOLD_W-1:0] cnt_q, cnt_d, eff_hold;
    logic              sw_q, sw_d;
    logic [LEN_W-1:0]  len_q, len_d;

    assign eff_hold = (hold_cfg < MIN_H) ? MIN_H : hold_cfg;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            sw_q    <= 1'b0;
            len_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sw_q    <= sw_d;
            len_q   <= len_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sw_d    = sw_q;
        len_d   = len_q;
        unique case (state_q)
            SQ_IDLE: begin
                len_d = '0;
                if (sw_req || err_rise) begin
                    state_d = SQ_CLEAR;
                    cnt_d   = eff_hold - 1'b1;
                    sw_d    = sw_req;
                end
            end
            SQ_CLEAR: begin
                len_d = len_q + 1'b1;
                if (cnt_q == '0) state_d = SQ_RELEASE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            SQ_RELEASE: state_d = SQ_IDLE;
            default:    state_d = SQ_IDLE;
        endcase
    end

    always_comb begin
        sclr    = (state_q == SQ_CLEAR);
        busy    = (state_q != SQ_IDLE);
        idle    = (state_q == SQ_IDLE);
        done    = (state_q == SQ_RELEASE);
        done_sw = (state_q == SQ_RELEASE) && sw_q;
    end

    // R5: the clear window is never shorter than the floor
    a_r5_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclr) |-> (len_q >= LEN_W'(MIN_HOLD)));
    // R6: release lasts one cycle and leads to idle
    a_r6_release_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_RELEASE) |=> (state_q == SQ_IDLE));
    // R6: the clear always ends through the release state
    a_r6_clear_to_release: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclr) |-> (state_q == SQ_RELEASE));
endmodule

// File: rtl/lri_regs.sv
module lri_regs
    import lri_pkg::*;
#(
    parameter int DW       = 8,
    parameter int HOLD_W   = 8,
    parameter int NT       = 8,
    parameter int NR       = 8,
    parameter int HOLD_RST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              busy,
    input  logic              idle,
    input  logic              seq_done,
    input  logic              done_sw,
    input  logic              sysref_seen,
    output logic [DW-1:0]     rdata,
    output logic              sw_req,
    output logic              arm_q,
    output logic [HOLD_W-1:0] hold_q,
    output logic [NT-1:0]     txm_q,
    output logic [NR-1:0]     rxm_q
);
    logic          link_q;
    logic          wr_ctrl;
    logic [DW-1:0] rd_mux;

    assign wr_ctrl = we && (addr == A_CTRL);
    assign sw_req  = wr_ctrl && wdata[B_REQ] && idle;

    always_ff @(posedge clk) begin
        if (!rst_n)                   link_q <= 1'b0;
        else if (sw_req)              link_q <= 1'b1;
        else if (seq_done && done_sw) link_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                       arm_q <= 1'b0;
        else if (wr_ctrl && wdata[B_ARM]) arm_q <= 1'b1;
        else if (sysref_seen)             arm_q <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= HOLD_W'(HOLD_RST);
            txm_q  <= '0;
            rxm_q  <= '0;
        end else if (we) begin
            if (addr == A_HOLD) hold_q <= wdata[HOLD_W-1:0];
            if (addr == A_TXM)  txm_q  <= wdata[NT-1:0];
            if (addr == A_RXM)  rxm_q  <= wdata[NR-1:0];
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (addr)
            A_CTRL: begin
                rd_mux[B_REQ]  = link_q;
                rd_mux[B_ARM]  = arm_q;
                rd_mux[B_BUSY] = busy;
            end
            A_HOLD:  rd_mux[HOLD_W-1:0] = hold_q;
            A_TXM:   rd_mux[NT-1:0]     = txm_q;
            default: rd_mux[NR-1:0]     = rxm_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= rd_mux;
    end

    // R7: a request written while busy does not set the bit
    a_r7_busy_req_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_ctrl && wdata[B_REQ] && !link_q) |=> !link_q);
    // R2: completion of a software sequence clears the request
    a_r2_sw_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && done_sw) |=> !link_q);
    // R4: an error-started sequence never shows the request
    a_r4_err_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done && !done_sw) |-> !link_q);
    // R10: the arm flag moves only on its own write or seen edge
    a_r10_arm_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_ctrl && wdata[B_ARM]) && !sysref_seen) |=> (arm_q == $past(arm_q)));
endmodule

// File: rtl/lnk_reinit_ctrl.sv
module lnk_reinit_ctrl
    import lri_pkg::*;
#(
    parameter int DW       = 8,
    parameter int HOLD_W   = 8,
    parameter int NT       = 8,
    parameter int NR       = 8,
    parameter int MIN_HOLD = 4,
    parameter int HOLD_RST = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic              csr_re,
    input  logic [ADDR_W-1:0] csr_addr,
    input  logic [DW-1:0]     csr_wdata,
    output logic [DW-1:0]     csr_rdata,
    input  logic [NT-1:0]     tx_err_in,
    input  logic [NR-1:0]     rx_err_in,
    input  logic              sysref_seen,
    output logic              tl_ll_sclr,
    output logic              reinit_busy,
    output logic              sysref_arm
);
    logic              sw_req, err_rise, idle, done, done_sw;
    logic [HOLD_W-1:0] hold_q;
    logic [NT-1:0]     txm_q;
    logic [NR-1:0]     rxm_q;

    lri_regs #(
        .DW(DW), .HOLD_W(HOLD_W), .NT(NT), .NR(NR), .HOLD_RST(HOLD_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(csr_we), .re(csr_re),
        .addr(csr_addr), .wdata(csr_wdata),
        .busy(reinit_busy), .idle(idle), .seq_done(done), .done_sw(done_sw),
        .sysref_seen(sysref_seen), .rdata(csr_rdata), .sw_req(sw_req),
        .arm_q(sysref_arm), .hold_q(hold_q), .txm_q(txm_q), .rxm_q(rxm_q)
    );

    lri_err_qual #(.NT(NT), .NR(NR)) u_qual (
        .clk(clk), .rst_n(rst_n), .tx_err(tx_err_in), .rx_err(rx_err_in),
        .tx_mask(txm_q), .rx_mask(rxm_q), .err_rise(err_rise)
    );

    lri_seq #(.HOLD_W(HOLD_W), .MIN_HOLD(MIN_HOLD)) u_seq (
        .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .err_rise(err_rise),
        .hold_cfg(hold_q), .sclr(tl_ll_sclr), .busy(reinit_busy),
        .idle(idle), .done(done), .done_sw(done_sw)
    );

    // R1: the clear is only ever driven inside a busy window
    a_r1_sclr_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tl_ll_sclr |-> reinit_busy);
    // R7: a trigger seen during busy does not extend the window
    a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (reinit_busy && !tl_ll_sclr) |=> !tl_ll_sclr);
endmodule

// File: tb/sim_lnk_reinit_ctrl.sv
`timescale 1ns/1ps
module sim_lnk_reinit_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0, re = 1'b0, seen = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0, tx_err = 8'd0, rx_err = 8'd0;
    logic [7:0] rdata;
    logic       sclr, busy, arm;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    lnk_reinit_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .csr_we(we), .csr_re(re), .csr_addr(addr),
        .csr_wdata(wdata), .csr_rdata(rdata), .tx_err_in(tx_err),
        .rx_err_in(rx_err), .sysref_seen(seen), .tl_ll_sclr(sclr),
        .reinit_busy(busy), .sysref_arm(arm)
    );

    // behavioural reference model
    int       m_state = 0, m_cnt = 0;
    bit       m_sw = 0, m_link = 0, m_arm = 0, m_prev = 0;
    bit [7:0] m_hold = 8, m_txm = 0, m_rxm = 0, m_rd = 0;

    always @(posedge clk) begin
        bit comb, rise, idle, sw, start, done;
        int eff;
        bit [7:0] rv;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_sw = 0; m_link = 0; m_arm = 0;
            m_prev = 0; m_hold = 8; m_txm = 0; m_rxm = 0; m_rd = 0;
        end else begin
            comb  = ((tx_err & m_txm) != 0) || ((rx_err & m_rxm) != 0);
            rise  = comb && !m_prev;
            idle  = (m_state == 0);
            done  = (m_state == 2);
            sw    = we && addr == 2'd0 && wdata[0] && idle;
            start = idle && (sw || rise);
            case (addr)
                2'd0:    rv = {5'd0, m_state != 0, m_arm, m_link};
                2'd1:    rv = m_hold;
                2'd2:    rv = m_txm;
                default: rv = m_rxm;
            endcase
            if (re) m_rd = rv;
            eff = (m_hold < 4) ? 4 : int'(m_hold);
            if (m_state == 0) begin
                if (start) begin m_state = 1; m_cnt = eff; m_sw = sw; end
            end else if (m_state == 1) begin
                m_cnt = m_cnt - 1;
                if (m_cnt == 0) m_state = 2;
            end else m_state = 0;
            if (sw) m_link = 1;
            else if (done && m_sw) m_link = 0;
            if (we && addr == 2'd0 && wdata[1]) m_arm = 1;
            else if (seen) m_arm = 0;
            if (we && addr == 2'd1) m_hold = wdata;
            if (we && addr == 2'd2) m_txm = wdata;
            if (we && addr == 2'd3) m_rxm = wdata;
            m_prev = comb;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R5 model clear", int'(sclr), int'(m_state == 1));
            chk("R1 model busy", int'(busy), int'(m_state != 0));
            chk("R10 model arm", int'(arm), int'(m_arm));
            chk("R11 model rdata", int'(rdata), int'(m_rd));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0; wdata = 8'd0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk); re = 1'b1; addr = a;
        @(negedge clk); re = 1'b0; v = int'(rdata);
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 1000 && busy; k++) @(negedge clk);
    endtask

    task automatic measure(output int len);
        len = 0;
        for (int k = 0; k < 1000 && sclr; k++) begin len++; @(negedge clk); end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int v, len;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 reset clear", int'(sclr), 0);
        chk("R11 reset busy", int'(busy), 0);
        chk("R11 reset arm", int'(arm), 0);
        rd(2'd0, v); chk("R11 reset ctrl", v, 0);
        rd(2'd1, v); chk("R11 reset hold", v, 8);

        // software start, default hold
        wr(2'd0, 8'h01);
        chk("R1 clear after request", int'(sclr), 1);
        measure(len); chk("R5 hold 8", len, 8);
        chk("R6 busy in release", int'(busy), 1);
        @(negedge clk); chk("R6 busy after release", int'(busy), 0);
        rd(2'd0, v); chk("R2 ctrl after sw done", v, 0);

        wr(2'd0, 8'h01);
        rd(2'd0, v); chk("R1 ctrl during sw", v, 5);
        wait_idle(); rd(2'd0, v); chk("R2 ctrl after second sw", v, 0);

        // hold floor and programmed length
        wr(2'd1, 8'd2); wr(2'd0, 8'h01); measure(len); chk("R5 floor from 2", len, 4);
        wait_idle();
        wr(2'd1, 8'd0); wr(2'd0, 8'h01); measure(len); chk("R5 floor from 0", len, 4);
        wait_idle();
        wr(2'd1, 8'd6); wr(2'd0, 8'h01); measure(len); chk("R5 hold 6", len, 6);
        wait_idle();

        // masked error
        @(negedge clk); tx_err = 8'h08;
        repeat (5) @(negedge clk); chk("R3 disabled error ignored", int'(busy), 0);
        tx_err = 8'h00;
        wr(2'd2, 8'h08);
        tx_err = 8'h08;
        @(negedge clk); chk("R3 enabled error starts", int'(busy), 1);
        rd(2'd0, v); chk("R4 ctrl during err", v, 4);
        tx_err = 8'h00;
        wait_idle(); rd(2'd0, v); chk("R4 ctrl after err", v, 0);

        // stuck error and late mask enable
        wr(2'd3, 8'h02);
        rx_err = 8'h02;
        @(negedge clk); chk("R3 rx error starts", int'(busy), 1);
        wait_idle(); repeat (20) @(negedge clk);
        chk("R8 stuck no retrigger", int'(busy), 0);
        rx_err = 8'h00; @(negedge clk);
        tx_err = 8'h20; repeat (3) @(negedge clk);
        chk("R8 unmasked held error", int'(busy), 0);
        wr(2'd2, 8'h28);
        @(negedge clk); chk("R8 mask enable starts", int'(busy), 1);
        tx_err = 8'h00; wait_idle();

        // triggers while busy
        wr(2'd0, 8'h01);
        tx_err = 8'h08; @(negedge clk); tx_err = 8'h00;
        wr(2'd0, 8'h01);
        for (int k = 0; k < 100 && sclr; k++) @(negedge clk);
        tx_err = 8'h08; @(negedge clk); tx_err = 8'h00;
        repeat (5) @(negedge clk); chk("R7 no follow-on", int'(busy), 0);
        rd(2'd0, v); chk("R7 ctrl after busy triggers", v, 0);

        // simultaneous software and error
        @(negedge clk); we = 1'b1; addr = 2'd0; wdata = 8'h01; tx_err = 8'h08;
        @(negedge clk); we = 1'b0; wdata = 8'h00; tx_err = 8'h00;
        rd(2'd0, v); chk("R9 ctrl during simultaneous", v, 5);
        wait_idle(); rd(2'd0, v); chk("R9 ctrl after simultaneous", v, 0);

        // arm and register retention
        wr(2'd0, 8'h02); chk("R10 arm set", int'(arm), 1);
        wr(2'd0, 8'h01); wait_idle();
        chk("R10 arm kept", int'(arm), 1);
        rd(2'd2, v); chk("R10 tx mask kept", v, 8'h28);
        rd(2'd3, v); chk("R10 rx mask kept", v, 8'h02);
        rd(2'd1, v); chk("R10 hold kept", v, 6);
        @(negedge clk); seen = 1'b1; @(negedge clk); seen = 1'b0;
        chk("R10 arm cleared by seen", int'(arm), 0);

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule